// File: doc/BRIEF.md
# Timer Input Capture Channel

The block is one input-capture channel with its own 16-bit free-running timer. The timer advances on a tick. The tick comes from a power-of-two divider of the bus clock, or from rising edges on an external clock pin. A single capture input passes through a synchronizer and an edge detector whose polarity software selects. On each qualifying transition, the current timer value is latched into a 16-bit capture register.

Software reaches the channel through a small byte-wide register port with four addresses. It can enable an interrupt and poll a sticky event flag. It reads the captured time as a high byte and a low byte, and reading the high byte first keeps the two halves from tearing. The flag is cleared by a read-then-write handshake, so a stray write cannot lose an event.

Top module: `cap_channel`

## Requirements
- R1: The timer reads 0 after reset. In bus-clock mode (clock-select value p from 0 to 6), it adds one, wrapping at 16 bits, on every 2^p-th bus cycle. These are the cycles where the free divider counted from reset satisfies (n mod 2^p) = 2^p-1.
- R2: With clock-select value 7, the timer adds one for each rising edge on `ext_clk`. An edge first sampled at clock edge k increments the timer at edge k+2.
- R3: Register map on `bus_addr`: 0 is status/control, 1 is the capture bits 15:8, 2 is the capture bits 7:0, and 3 is clock select in bits 2:0. `bus_rdata` shows the addressed register combinationally.
- R4: Status bits 3:2 pick the active capture transition: 00 none, 01 rising, 10 falling, 11 both. A transition of `cap_in` first sampled at clock edge k loads the timer value held before edge k+2 into the capture register at edge k+2.
- R5: Every active transition overwrites the capture register, whether or not the flag is already set.
- R6: Each active transition sets the flag (status bit 7). `irq` is high exactly while the flag and the interrupt enable (status bit 6) are both 1.
- R7: The flag clears only on a status write with bit 7 = 0 that follows a status read which saw the flag at 1. Writing 1 to bit 7 has no effect. A capture in the same cycle as the clearing write leaves the flag set.
- R8: A high-byte read freezes the capture register until the next low-byte read. A capture in that window, or in the cycle of the high-byte read, is held back and applied at the low-byte read. A capture in the same cycle as the low-byte read takes precedence.
- R9: After reset the status register and the clock select read 0. Status bits 5, 4, 1 and 0 always read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk | input | 1 | External timer clock pin (asynchronous) |
| cap_in | input | 1 | Capture input pin (asynchronous) |
| bus_addr | input | 2 | Register select |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Interrupt request |
| count_o | output | 16 | Current timer value |

## Verification
The hardest situation to reach is a capture that falls in the same cycle as a high-byte read, a low-byte read, or the flag-clearing write. The capture lands two cycles after the pin moves, so hitting those cycles by hand means counting synchronizer stages exactly. The stimulus therefore sweeps the delay between a pin transition and the register access over several consecutive offsets. One of those offsets lines each access up with the internal capture strobe. A cycle-accurate behavioural model then decides, every cycle, what the read port, the timer and the interrupt must show.

// File: rtl/cap_pkg.sv
package cap_pkg;

    localparam int BYTE_W   = 8;
    localparam int CNT_W    = 2 * BYTE_W;
    localparam int PS_W     = 3;
    localparam int NUM_DIV  = 7;
    localparam int ADDR_W   = 2;
    localparam int SYNC_LEN = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_STAT   = 2'd0,
        ADDR_CAP_HI = 2'd1,
        ADDR_CAP_LO = 2'd2,
        ADDR_CLKSEL = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_sel_e;

    // Status/control byte as seen on the read port.
    typedef struct packed {
        logic       flag;
        logic       ie;
        logic [1:0] mode_zero;
        edge_sel_e  esel;
        logic [1:0] tail_zero;
    } stat_t;

    function automatic logic edge_hit(edge_sel_e sel, logic cur, logic prev);
        case (sel)
            EDGE_RISE: return cur & ~prev;
            EDGE_FALL: return ~cur & prev;
            EDGE_ANY:  return cur ^ prev;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/cap_prescaler.sv
module cap_prescaler
    import cap_pkg::*;
#(
    parameter int P_PS_W   = PS_W,
    parameter int P_DIVS   = NUM_DIV,
    parameter int P_SYNC   = SYNC_LEN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [P_PS_W-1:0] ps,
    input  logic              ext_clk,
    output logic              tick
);
    localparam int DIV_W = (P_DIVS > 1) ? P_DIVS - 1 : 1;
    localparam logic [P_PS_W-1:0] EXT_SEL = P_PS_W'(P_DIVS);

    logic [DIV_W-1:0]  div_q;
    logic [P_DIVS-1:0] rate_tick;
    logic [P_SYNC:0]   ext_sh;
    logic              ext_tick;

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_q + 1'b1;
    end

    // One tick source per divide ratio 2^g.
    for (genvar g = 0; g < P_DIVS; g++) begin : g_rate
        if (g == 0) begin : g_full
            assign rate_tick[g] = 1'b1;
        end else begin : g_div
            assign rate_tick[g] = &div_q[g-1:0];
        end
    end

    // External pin: synchronizer chain plus one previous-value stage.
    always_ff @(posedge clk) begin
        if (rst) ext_sh <= '0;
        else     ext_sh <= {ext_sh[P_SYNC-1:0], ext_clk};
    end

    assign ext_tick = ext_sh[P_SYNC-1] & ~ext_sh[P_SYNC];

    always_comb begin
        if (ps == EXT_SEL)            tick = ext_tick;
        else if (ps < EXT_SEL)        tick = rate_tick[ps];
        else                          tick = 1'b0;
    end

    AST_EXT_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        (ps == EXT_SEL && tick) |=> !(ps == EXT_SEL && tick)); // R2

endmodule

// File: rtl/cap_edge_detect.sv
module cap_edge_detect
    import cap_pkg::*;
#(
    parameter int P_SYNC = SYNC_LEN
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin,
    input  edge_sel_e esel,
    output logic      hit
);
    logic [P_SYNC:0] pin_sh;

    always_ff @(posedge clk) begin
        if (rst) pin_sh <= '0;
        else     pin_sh <= {pin_sh[P_SYNC-1:0], pin};
    end

    assign hit = edge_hit(esel, pin_sh[P_SYNC-1], pin_sh[P_SYNC]);

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
        (esel == EDGE_OFF) |-> !hit); // R4
    AST_RISE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (esel == EDGE_RISE && hit) |=> pin_sh[P_SYNC]); // R4

endmodule

// File: rtl/cap_latch.sv
module cap_latch
    import cap_pkg::*;
#(
    parameter int P_CNT_W = CNT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hit,
    input  logic [P_CNT_W-1:0] count,
    input  logic               hi_rd,
    input  logic               lo_rd,
    output logic [P_CNT_W-1:0] cap
);
    logic [P_CNT_W-1:0] cap_q;
    logic [P_CNT_W-1:0] pval_q;
    logic               pend_q;
    logic               frozen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q    <= '0;
            pval_q   <= '0;
            pend_q   <= 1'b0;
            frozen_q <= 1'b0;
        end else begin
            if (lo_rd && frozen_q) begin
                frozen_q <= 1'b0;
                pend_q   <= 1'b0;
                if (hit)         cap_q <= count;
                else if (pend_q) cap_q <= pval_q;
            end else if (hit) begin
                if (frozen_q || hi_rd) begin
                    pend_q <= 1'b1;
                    pval_q <= count;
                end else begin
                    cap_q <= count;
                end
            end
            if (hi_rd) frozen_q <= 1'b1;
        end
    end

    assign cap = cap_q;

    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (rst)
        ((frozen_q || hi_rd) && !lo_rd) |=> $stable(cap_q)); // R8
    AST_PENDING_APPLY: assert property (@(posedge clk) disable iff (rst)
        (frozen_q && lo_rd && pend_q && !hit) |=> (cap_q == $past(pval_q))); // R8
    AST_LIVE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (hit && !frozen_q && !hi_rd) |=> (cap_q == $past(count))); // R5

endmodule

// File: rtl/cap_channel.sv
module cap_channel
    import cap_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                ext_clk,
    input  logic                cap_in,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_rd,
    input  logic                bus_wr,
    input  logic [BYTE_W-1:0]   bus_wdata,
    output logic [BYTE_W-1:0]   bus_rdata,
    output logic                irq,
    output logic [CNT_W-1:0]    count_o
);
    reg_addr_e        addr;
    stat_t            wstat;
    stat_t            rstat;
    logic             tick;
    logic             hit;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] cap;
    logic [PS_W-1:0]  ps_q;
    logic             flag_q;
    logic             ie_q;
    logic             arm_q;
    edge_sel_e        esel_q;
    logic             hi_rd;
    logic             lo_rd;
    logic             stat_wr;
    logic             unused_wbits;

    assign addr    = reg_addr_e'(bus_addr);
    assign wstat   = stat_t'(bus_wdata);
    assign hi_rd   = bus_rd && addr == ADDR_CAP_HI;
    assign lo_rd   = bus_rd && addr == ADDR_CAP_LO;
    assign stat_wr = bus_wr && addr == ADDR_STAT;
    assign unused_wbits = ^{wstat.mode_zero, wstat.tail_zero};

    cap_prescaler #(.P_PS_W(PS_W), .P_DIVS(NUM_DIV), .P_SYNC(SYNC_LEN)) u_presc (
        .clk(clk), .rst(rst), .ps(ps_q), .ext_clk(ext_clk), .tick(tick)
    );

    cap_edge_detect #(.P_SYNC(SYNC_LEN)) u_edge (
        .clk(clk), .rst(rst), .pin(cap_in), .esel(esel_q), .hit(hit)
    );

    cap_latch #(.P_CNT_W(CNT_W)) u_latch (
        .clk(clk), .rst(rst), .hit(hit), .count(count_q),
        .hi_rd(hi_rd), .lo_rd(lo_rd), .cap(cap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            ps_q    <= '0;
            flag_q  <= 1'b0;
            ie_q    <= 1'b0;
            arm_q   <= 1'b0;
            esel_q  <= EDGE_OFF;
        end else begin
            if (tick) count_q <= count_q + 1'b1;
            if (bus_rd && addr == ADDR_STAT && flag_q) arm_q <= 1'b1;
            if (stat_wr) begin
                ie_q   <= wstat.ie;
                esel_q <= wstat.esel;
                arm_q  <= 1'b0;
                if (arm_q && !wstat.flag) flag_q <= 1'b0;
            end
            if (bus_wr && addr == ADDR_CLKSEL) ps_q <= bus_wdata[PS_W-1:0];
            if (hit) flag_q <= 1'b1;
        end
    end

    always_comb begin
        rstat           = '0;
        rstat.flag      = flag_q;
        rstat.ie        = ie_q;
        rstat.esel      = esel_q;
        case (addr)
            ADDR_STAT:   bus_rdata = rstat;
            ADDR_CAP_HI: bus_rdata = cap[CNT_W-1:BYTE_W];
            ADDR_CAP_LO: bus_rdata = cap[BYTE_W-1:0];
            default:     bus_rdata = {{(BYTE_W-PS_W){1'b0}}, ps_q};
        endcase
    end

    assign irq     = flag_q & ie_q;
    assign count_o = count_q;

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        tick |=> (count_q == $past(count_q) + 1'b1)); // R1
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(count_q)); // R1
    AST_FLAG_ON_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        hit |=> flag_q); // R6
    AST_WRITE_ONE_INERT: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && !flag_q && !hit) |=> !flag_q); // R7
    AST_UNARMED_KEEP: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !arm_q && !(bus_rd && addr == ADDR_STAT)) |=> flag_q); // R7

endmodule

// File: tb/cap_channel_bench.sv
module cap_channel_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_clk = 1'b0;
    logic        cap_in = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = 8'd0;
    logic [7:0]  bus_rdata;
    logic        irq;
    logic [15:0] count_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    cap_channel u_cap_channel (
        .clk(clk), .rst(rst), .ext_clk(ext_clk), .cap_in(cap_in),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .count_o(count_o)
    );

    // Behavioural reference model.
    int          m_count, m_div;
    bit          m_flag, m_ie, m_arm, m_froz, m_pend, m_known;
    logic [1:0]  m_els;
    logic [2:0]  m_ps;
    logic [15:0] m_cap, m_pval;
    bit          pin_hist[$];
    bit          ext_hist[$];

    always @(posedge clk) begin
        if (rst) begin
            m_count = 0; m_div = 0; m_flag = 0; m_ie = 0; m_arm = 0;
            m_froz = 0; m_pend = 0; m_known = 0; m_els = 2'b00; m_ps = 3'd0;
            m_cap = 16'd0; m_pval = 16'd0;
            pin_hist = '{0, 0, 0};
            ext_hist = '{0, 0, 0};
        end else begin
            bit nw, od, hit, tk, hi, lo;
            int old_count;
            nw = pin_hist[1]; od = pin_hist[2];
            case (m_els)
                2'b01:   hit = nw && !od;
                2'b10:   hit = !nw && od;
                2'b11:   hit = nw != od;
                default: hit = 0;
            endcase
            if (m_ps == 3'd7) tk = ext_hist[1] && !ext_hist[2];
            else              tk = (m_div % (1 << m_ps)) == ((1 << m_ps) - 1);
            old_count = m_count;
            hi = bus_rd && bus_addr == 2'd1;
            lo = bus_rd && bus_addr == 2'd2;
            if (lo && m_froz) begin
                m_froz = 0;
                if (hit) begin m_cap = 16'(old_count); m_known = 1; end
                else if (m_pend) m_cap = m_pval;
                m_pend = 0;
            end else if (hit) begin
                if (m_froz || hi) begin m_pend = 1; m_pval = 16'(old_count); end
                else begin m_cap = 16'(old_count); m_known = 1; end
            end
            if (hi) m_froz = 1;
            if (bus_rd && bus_addr == 2'd0 && m_flag) m_arm = 1;
            if (bus_wr && bus_addr == 2'd0) begin
                m_ie = bus_wdata[6];
                m_els = bus_wdata[3:2];
                if (m_arm && !bus_wdata[7]) m_flag = 0;
                m_arm = 0;
            end
            if (bus_wr && bus_addr == 2'd3) m_ps = bus_wdata[2:0];
            if (hit) m_flag = 1;
            if (tk) m_count = (m_count + 1) % 65536;
            m_div = (m_div + 1) % 64;
            pin_hist.push_front(cap_in); void'(pin_hist.pop_back());
            ext_hist.push_front(ext_clk); void'(ext_hist.pop_back());
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        int exp_rd;
        chk(count_o == 16'(m_count), "R1 R2 timer value", count_o, m_count);
        chk(irq == (m_flag && m_ie), "R6 irq", irq, m_flag && m_ie);
        case (bus_addr)
            2'd0: begin
                exp_rd = {m_flag, m_ie, 2'b00, m_els, 2'b00};
                chk(bus_rdata == 8'(exp_rd), "R6 R7 R9 status", bus_rdata, exp_rd);
            end
            2'd1: if (m_known)
                chk(bus_rdata == m_cap[15:8], "R3 R4 R5 R8 capture high", bus_rdata, m_cap[15:8]);
            2'd2: if (m_known)
                chk(bus_rdata == m_cap[7:0], "R3 R8 capture low", bus_rdata, m_cap[7:0]);
            default: chk(bus_rdata == {5'd0, m_ps}, "R3 R9 clock select", bus_rdata, m_ps);
        endcase
    endtask

    task automatic step();
        @(negedge clk);
        if (!rst) compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a);
        bus_addr = a; bus_rd = 1'b1;
        step();
        bus_rd = 1'b0;
    endtask

    task automatic pin(input bit v, input int hold);
        cap_in = v;
        idle(hold);
    endtask

    task automatic clear_flag();
        rd(2'd0);
        wr(2'd0, {1'b0, m_ie, 2'b00, m_els, 2'b00});
    endtask

    initial begin
        #4000000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        bus_addr = 2'd0; #1;
        chk(bus_rdata == 8'd0, "R9 status after reset", bus_rdata, 0);
        chk(count_o == 16'd0, "R1 timer after reset", count_o, 0);
        chk(irq == 1'b0, "R6 irq after reset", irq, 0);
        bus_addr = 2'd3; #1;
        chk(bus_rdata == 8'd0, "R9 clock select after reset", bus_rdata, 0);
        @(negedge clk);
        rst = 1'b0;
        bus_addr = 2'd0;

        // Rising only, interrupt on (R4, R6).
        wr(2'd0, 8'h44); idle(5);
        pin(1, 6); rd(2'd1); rd(2'd2);
        pin(0, 6);                       // falling edge ignored in rise mode
        pin(1, 3); pin(0, 3); pin(1, 6); // R5 overwrite while flag set
        rd(2'd1); rd(2'd2);
        wr(2'd0, 8'hC4); idle(2);        // R7 no arm: flag stays
        wr(2'd0, 8'h44); idle(2);        // R7 still no arm
        clear_flag(); idle(3);
        wr(2'd0, 8'hF4); idle(2);        // R9 writes to spare bits ignored
        // Falling, both, disabled (R4).
        wr(2'd0, 8'h48); pin(0, 5); pin(1, 5); rd(2'd1); rd(2'd2); clear_flag();
        wr(2'd0, 8'h4C); pin(0, 1); pin(1, 1); pin(0, 6); rd(2'd1); rd(2'd2); clear_flag();
        wr(2'd0, 8'h40); pin(1, 5); pin(0, 5); idle(3);
        // Divider sweep (R1).
        for (int p = 1; p < 7; p++) begin
            wr(2'd3, 8'(p)); wr(2'd0, 8'h4C);
            idle(130);
            pin(~cap_in, 40 + p); rd(2'd1); rd(2'd2);
            clear_flag();
        end
        // Capture against read/clear timing (R7, R8).
        wr(2'd3, 8'd0); wr(2'd0, 8'h4C);
        for (int off = 0; off < 6; off++) begin
            pin(~cap_in, off); rd(2'd1); idle(2);
            pin(~cap_in, off); rd(2'd2); idle(3);
            rd(2'd1); rd(2'd2);
            rd(2'd0); pin(~cap_in, off);
            wr(2'd0, 8'h0C); idle(4);
            rd(2'd1); pin(~cap_in, 3); pin(~cap_in, 3); rd(2'd2); rd(2'd1); rd(2'd2);
        end
        // External clock (R2).
        wr(2'd3, 8'd7); wr(2'd0, 8'h4C);
        for (int k = 1; k < 5; k++) begin
            for (int j = 0; j < 6; j++) begin
                ext_clk = 1'b1; idle(k);
                ext_clk = 1'b0; idle(k);
            end
            pin(~cap_in, 4); rd(2'd1); rd(2'd2);
        end
        idle(8);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule